// File: doc/BRIEF.md
# Stereo First-Order De-Emphasis Filter

This block sits in the sample path ahead of a DAC's interpolator and applies a first-order recursive filter to each of two audio channels. One strobe carries a left and a right 16-bit signed sample. Two clock edges later the block presents the filtered pair with its own one-cycle strobe. The filter output is built from three signed 16-bit coefficients per channel, and the feedback term is anchored against a fixed denominator of 2^15. In transfer-function form:

y[n] = (N0·x[n] + N1·x[n−1] + D1·y[n−1]) / 32768

Out of reset the coefficients on both channels implement de-emphasis for a 48 kHz sample rate. A narrow write port reprograms any coefficient of either channel, so the same datapath serves the 44.1 kHz and 32 kHz de-emphasis curves, or any other first-order response. Writes go to a staging copy. The staging copy is moved into the working set only on a sample strobe, so both channels of one frame always use one consistent coefficient set. A bypass control passes samples through with the same latency and clears the filter history.

Top module: `deemph_filter`

## Requirements
- R1: After reset, out_valid is low and out_left and out_right are zero. Both channels use N0 = 14677, N1 = −3283 and D1 = 21374 until they are reprogrammed.
- R2: Each filtered output is floor((N0·x[n] + N1·x[n−1] + D1·y[n−1]) / 2^15) for its own channel. x and y are the previous input and previous output of that channel, and both start at zero after reset.
- R3: A result above 32767 is clamped to 32767 and one below −32768 is clamped to −32768. The clamped value is the y[n−1] used by the next sample.
- R4: For every cycle in which in_valid is sampled high, out_valid pulses for exactly one cycle, two rising edges later. Strobes on consecutive cycles are each processed.
- R5: A cycle with cfg_we high writes cfg_data into one staged coefficient. The channel is chosen by cfg_chan (0 left, 1 right) and the coefficient by cfg_sel (0 N0, 1 N1, 2 D1). cfg_sel = 3 changes nothing, and the other channel is never touched.
- R6: Staged coefficients become active only on a sample strobe. A write made in the same cycle as a strobe applies from the following strobe.
- R7: When bypass is high together with in_valid, that sample leaves unchanged with the R4 latency. Both history terms of both channels are cleared to zero.
- R8: Any coefficient values work through the same datapath, including the 44.1 kHz set (15091, −2877, 20555) and the 32 kHz set (16950, −1220, 17037).
- R9: Between result strobes, out_left and out_right hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_chan | input | 1 | Channel of the write: 0 left, 1 right |
| cfg_sel | input | 2 | Coefficient of the write: 0 N0, 1 N1, 2 D1, 3 none |
| cfg_data | input | 16 | Signed coefficient value |
| bypass | input | 1 | Pass-through request, sampled with in_valid |
| in_valid | input | 1 | Input frame strobe |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| out_valid | output | 1 | Output frame strobe |
| out_left | output | 16 | Left output sample, signed |
| out_right | output | 16 | Right output sample, signed |

## Verification
The assertions assume that rst_n is held low for at least one edge before any traffic. They also assume that bypass only has meaning in cycles where in_valid is high, because the pass-through check compares against the input that was present two edges earlier with the strobe. The stimulus follows both rules. It changes every input on the falling clock edge, and it allows strobes on back-to-back cycles, which the latency properties accept, but it never raises a strobe during reset. Coefficient writes are placed both between frames and in the same cycle as a strobe. This exercises the staged-to-active handover, whose property assumes that the working set changes only on edges where a strobe was sampled.

// File: rtl/deemph_pkg.sv
// Shared widths, types and constants for the stereo first-order de-emphasis filter.
// Assumes two's complement samples and coefficients of equal word length.
package deemph_pkg;

    localparam int DATA_W = 16;                       // audio sample width
    localparam int COEF_W = 16;                       // coefficient width
    localparam int FRAC_W = 15;                       // fixed denominator is 2**FRAC_W
    localparam int NCH    = 2;                        // left and right
    localparam int CHAN_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int ACC_W  = DATA_W + COEF_W + 2;      // three products summed

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        coef_t n0;   // weight of the current input
        coef_t n1;   // weight of the previous input
        coef_t d1;   // weight of the previous output
    } coef_set_t;

    typedef enum logic [1:0] {
        SEL_N0   = 2'd0,
        SEL_N1   = 2'd1,
        SEL_D1   = 2'd2,
        SEL_NONE = 2'd3
    } coef_sel_e;

    // 48 kHz de-emphasis response loaded at reset
    localparam coef_set_t DEFAULT_SET = '{
        n0: coef_t'(14677),
        n1: coef_t'(-3283),
        d1: coef_t'(21374)
    };

    localparam acc_t SAMPLE_MAX = acc_t'((2 ** (DATA_W - 1)) - 1);
    localparam acc_t SAMPLE_MIN = acc_t'(-(2 ** (DATA_W - 1)));

    // Clamp a wide signed value into the sample range.
    function automatic sample_t clip_sample(input acc_t v);
        if (v > SAMPLE_MAX) begin
            return sample_t'(SAMPLE_MAX);
        end else if (v < SAMPLE_MIN) begin
            return sample_t'(SAMPLE_MIN);
        end
        return sample_t'(v);
    endfunction

endpackage

// File: rtl/deemph_coef_bank.sv
// Coefficient storage for one channel: a staged copy written by the
// configuration port and a working copy refreshed only on a sample strobe.
// Assumes wr_en is already qualified with the channel select.
module deemph_coef_bank
    import deemph_pkg::*;
#(
    parameter coef_set_t RST_SET = DEFAULT_SET
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  coef_sel_e wr_sel,
    input  coef_t     wr_data,
    input  logic      load,
    output coef_set_t active
);

    coef_set_t staged;

    // Staged copy: take a single field per write, ignore the unused code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= RST_SET;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_N0:  staged.n0 <= wr_data;
                SEL_N1:  staged.n1 <= wr_data;
                SEL_D1:  staged.d1 <= wr_data;
                default: staged    <= staged;
            endcase
        end
    end

    // Working copy: refreshed from the staged copy on each input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= RST_SET;
        end else if (load) begin
            active <= staged;
        end
    end

endmodule

// File: rtl/deemph_section.sv
// One channel of the first-order recursive filter, two stages deep.
// Stage 1 captures the sample and bypass flag. Stage 2 forms
// N0*x + N1*x1 + D1*y1, shifts by FRAC_W, clamps the result and updates the history.
// Assumes coefs holds the set that was made active with the captured strobe.
module deemph_section
    import deemph_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      bypass,
    input  sample_t   x_in,
    input  coef_set_t coefs,
    output logic      y_valid,
    output sample_t   y_out
);

    sample_t x_q;
    logic    bp_q;
    logic    v_q;
    sample_t x_hist;
    sample_t y_hist;
    acc_t    acc;
    acc_t    acc_shr;
    sample_t y_next;

    // Stage 1: register the incoming sample and its bypass request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= 1'b0;
            x_q  <= '0;
            bp_q <= 1'b0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                x_q  <= x_in;
                bp_q <= bypass;
            end
        end
    end

    // Multiply-accumulate over the wide range, then scale and clamp.
    always_comb begin
        acc = acc_t'(coefs.n0) * acc_t'(x_q)
            + acc_t'(coefs.n1) * acc_t'(x_hist)
            + acc_t'(coefs.d1) * acc_t'(y_hist);
        acc_shr = acc >>> FRAC_W;
        y_next  = clip_sample(acc_shr);
    end

    // Stage 2: publish the result and update or clear the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_valid <= 1'b0;
            y_out   <= '0;
            x_hist  <= '0;
            y_hist  <= '0;
        end else begin
            y_valid <= v_q;
            if (v_q) begin
                if (bp_q) begin
                    y_out  <= x_q;
                    x_hist <= '0;
                    y_hist <= '0;
                end else begin
                    y_out  <= y_next;
                    x_hist <= x_q;
                    y_hist <= y_next;
                end
            end
        end
    end

endmodule

// File: rtl/deemph_filter.sv
// Top level of the stereo first-order de-emphasis filter.
// Builds one coefficient bank and one filter section per channel.
// Assumes left and right arrive together under one strobe.
module deemph_filter
    import deemph_pkg::*;
#(
    parameter coef_set_t RST_SET = DEFAULT_SET
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CHAN_W-1:0]        cfg_chan,
    input  logic [1:0]               cfg_sel,
    input  logic signed [COEF_W-1:0] cfg_data,
    input  logic                     bypass,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right
);

    sample_t   [NCH-1:0] in_s;
    sample_t   [NCH-1:0] out_s;
    logic      [NCH-1:0] vld;
    coef_set_t [NCH-1:0] act_set;
    coef_sel_e           sel_e;

    assign in_s[0] = in_left;
    assign in_s[1] = in_right;
    assign sel_e   = coef_sel_e'(cfg_sel);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;
        assign hit = cfg_we && (cfg_chan == CHAN_W'(ch));

        deemph_coef_bank #(
            .RST_SET (RST_SET)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hit),
            .wr_sel  (sel_e),
            .wr_data (cfg_data),
            .load    (in_valid),
            .active  (act_set[ch])
        );

        deemph_section u_sec (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .bypass   (bypass),
            .x_in     (in_s[ch]),
            .coefs    (act_set[ch]),
            .y_valid  (vld[ch]),
            .y_out    (out_s[ch])
        );
    end

    // The sections run in lockstep, so the frame is complete when all report.
    assign out_valid = &vld;
    assign out_left  = out_s[0];
    assign out_right = out_s[1];

endmodule

// File: rtl/deemph_checker.sv
// Protocol and timing properties of deemph_filter, bound to every instance.
// A small counter of edges since reset keeps $past from reaching back into reset.
module deemph_checker
    import deemph_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bypass,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_left,
    input logic signed [DATA_W-1:0] in_right,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_left,
    input logic signed [DATA_W-1:0] out_right,
    input coef_set_t [NCH-1:0]      act_set
);

    logic [1:0] since_rst;

    // Count edges since reset release, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> (!out_valid && out_left == '0 && out_right == '0));

    assert_strobe_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && out_valid) |-> $past(in_valid, 2));

    assert_coef_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !$past(in_valid)) |-> $stable(act_set));

    assert_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && out_valid && $past(in_valid, 2) && $past(bypass, 2))
        |-> (out_left == $past(in_left, 2) && out_right == $past(in_right, 2)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !out_valid) |-> ($stable(out_left) && $stable(out_right)));

endmodule

bind deemph_filter deemph_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bypass    (bypass),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .act_set   (act_set)
);

// File: tb/tb_deemph_filter.sv
module tb_deemph_filter;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [0:0]         cfg_chan = '0;
    logic [1:0]         cfg_sel = '0;
    logic signed [15:0] cfg_data = '0;
    logic               bypass = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_left = '0;
    logic signed [15:0] in_right = '0;
    logic               out_valid;
    logic signed [15:0] out_left;
    logic signed [15:0] out_right;

    always #2.5 clk = ~clk;

    deemph_filter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_chan  (cfg_chan),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .bypass    (bypass),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

    typedef struct {
        int    l;
        int    r;
        int    due;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   run = 0;
    bit   done = 0;
    bit   have_last = 0;
    int   last_l, last_r;

    // Reference model state: staged coefficients and history per channel.
    int stg[2][3];
    int xh[2];
    int yh[2];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int clip16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int model_step(input int ch, input int x, input bit bp);
        longint acc;
        int y;
        if (bp) begin
            xh[ch] = 0;
            yh[ch] = 0;
            return x;
        end
        acc = longint'(stg[ch][0]) * x + longint'(stg[ch][1]) * xh[ch]
            + longint'(stg[ch][2]) * yh[ch];
        y = clip16(acc >>> 15);
        xh[ch] = x;
        yh[ch] = y;
        return y;
    endfunction

    function automatic void model_reset();
        for (int ch = 0; ch < 2; ch++) begin
            stg[ch][0] = 14677;
            stg[ch][1] = -3283;
            stg[ch][2] = 21374;
            xh[ch] = 0;
            yh[ch] = 0;
        end
    endfunction

    // Driver: one frame strobe, optional coefficient write in the same cycle.
    task automatic frame(input int l, input int r, input bit bp, input string tag,
                         input int gap, input bit w = 0, input int wch = 0,
                         input int wsel = 0, input int wval = 0);
        exp_t e;
        in_valid = 1'b1;
        in_left  = 16'(l);
        in_right = 16'(r);
        bypass   = bp;
        cfg_we   = w;
        cfg_chan = 1'(wch);
        cfg_sel  = 2'(wsel);
        cfg_data = 16'(wval);
        e.l   = model_step(0, l, bp);
        e.r   = model_step(1, r, bp);
        e.due = cyc + 2;
        e.tag = tag;
        q.push_back(e);
        if (w && wsel < 3) stg[wch][wsel] = wval;
        @(negedge clk);
        in_valid = 1'b0;
        bypass   = 1'b0;
        cfg_we   = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wr(input int ch, input int sel, input int val);
        cfg_we   = 1'b1;
        cfg_chan = 1'(ch);
        cfg_sel  = 2'(sel);
        cfg_data = 16'(val);
        if (sel < 3) stg[ch][sel] = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_set(input int ch, input int a, input int b, input int c);
        wr(ch, 0, a);
        wr(ch, 1, b);
        wr(ch, 2, c);
    endtask

    // Monitor: pop the scoreboard on every result, watch holds in between.
    always @(negedge clk) begin
        if (rst_n && run) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.due, "R4 latency", cyc, e.due);
                    chk(int'(out_left) == e.l, {e.tag, " left"}, int'(out_left), e.l);
                    chk(int'(out_right) == e.r, {e.tag, " right"}, int'(out_right), e.r);
                end
                last_l = int'(out_left);
                last_r = int'(out_right);
                have_last = 1;
            end else if (have_last) begin
                chk(int'(out_left) == last_l && int'(out_right) == last_r,
                    "R9 hold", int'(out_left), last_l);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(out_left == 0 && out_right == 0, "R1 outputs zero", int'(out_left), 0);
        run = 1;

        // R1 / R2: default 48 kHz response to an impulse, spaced strobes
        frame(16384, -16384, 0, "R1", 3);
        for (int i = 0; i < 5; i++) frame(0, 0, 0, "R1", 2);

        // R2: varied inputs with independent histories
        frame(12000, -7000, 0, "R2", 1);
        frame(-20000, 30000, 0, "R2", 4);
        frame(32767, -32768, 0, "R2", 1);
        frame(-1, 1, 0, "R2", 1);

        // R4: strobes on consecutive cycles
        for (int i = 0; i < 6; i++) frame(i * 5000 - 12000, 9000 - i * 3000, 0, "R4", 0);
        repeat (3) @(negedge clk);

        // R8: 44.1 kHz set on left, 32 kHz set on right
        load_set(0, 15091, -2877, 20555);
        load_set(1, 16950, -1220, 17037);
        frame(20000, 20000, 0, "R8", 1);
        for (int i = 0; i < 4; i++) frame(0, 0, 0, "R8", 1);
        frame(-15000, 8000, 0, "R8", 0);

        // R5: select code 3 must leave both channels as they are
        wr(0, 3, -1);
        wr(1, 3, 1234);
        frame(10000, -10000, 0, "R5", 1);
        frame(0, 0, 0, "R5", 1);
        // R5: write to right only, left keeps its set
        wr(1, 0, 8000);
        frame(5000, 5000, 0, "R5", 1);

        // R6: write in the same cycle as a strobe applies from the next strobe
        frame(4000, 4000, 0, "R6", 0, 1, 0, 0, 30000);
        frame(4000, 4000, 0, "R6", 2);
        wr(0, 2, 0);
        frame(-4000, 0, 0, "R6", 1);

        // R3: drive into both clamps and carry the clamped value forward
        load_set(0, 32767, 32767, 32767);
        load_set(1, -32768, -32768, 32767);
        for (int i = 0; i < 3; i++) frame(32767, 32767, 0, "R3", 1);
        frame(0, 0, 0, "R3", 1);
        frame(-32768, -32768, 0, "R3", 0);
        frame(0, 0, 0, "R3", 2);

        // R7: bypass passes samples and clears history, then filtering resumes
        load_set(0, 14677, -3283, 21374);
        load_set(1, 14677, -3283, 21374);
        frame(9000, -9000, 0, "R7", 1);
        frame(1234, -4321, 1, "R7", 0);
        frame(-32768, 32767, 1, "R7", 2);
        frame(16384, 16384, 0, "R7", 0);
        frame(0, 0, 0, "R7", 3);

        repeat (6) @(negedge clk);
        chk(q.size() == 0, "R4 every strobe answered", q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule